// File: doc/BRIEF.md
# Burst-Wrap Splitter with Beat Mask Generation

This block sits between a memory controller's command sequencer and its write data path. It receives one master write transfer, given as a start column, a beat count and a device mode. It turns that transfer into device WRITE commands, each of which opens a fixed burst of eight beats, together with a per-beat stream of column and mask information for the data path. The device burst always stays inside an aligned group of eight columns. If a transfer would run past the end of its group, the block issues a new WRITE at the start of the next group, so the device never wraps. Beat slots of a WRITE that carry no requested data are masked.

Two device flavours are supported. In double-data-rate mode, write data follows the WRITE command by one cycle. A single-beat access is closed by masking the seven trailing slots. In single-data-rate mode, the first beat goes out in the same cycle as the WRITE. A single-beat access is closed by a burst-stop command in the following cycle instead of by masking. A one-cycle done pulse marks the end of each transfer.

Top module: `burst_wrap_splitter`

## Requirements
- R1: After reset, busy, cmdWrite, cmdStop, beatValid and done are all low.
- R2: The first WRITE of a transfer carries the start column on cmdCol. Every later WRITE carries a column whose three low bits are zero, equal to the column that follows the last beat of the previous WRITE.
- R3: The number of WRITE commands in a transfer equals ceil((startCol mod 8 + beats) / 8). The beat count is 1, 4, 8 or 16 for lenCode 0, 1, 2 or 3.
- R4: With sdrMode low, a WRITE cycle carries no beat. Eight beat slots follow on the next eight cycles.
- R5: With sdrMode high, slot 0 is valid in the same cycle as the WRITE. Slots 1 to 7 follow on the next seven cycles, except for a single access.
- R6: A single access (lenCode 0) with sdrMode low drives beatMask low on slot 0 and high on slots 1 to 7.
- R7: A single access with sdrMode high drives cmdStop for one cycle right after the WRITE cycle, and there is no other beat slot. cmdWrite and cmdStop are never high together.
- R8: In slot k of a WRITE issued at column c with n requested beats, beatCol is the group base of c plus ((c mod 8 + k) mod 8). beatMask (high = ignore) is high exactly when k >= n.
- R9: done is high for one cycle, in the cycle after the last beat slot or after the burst stop. busy is low from the following cycle.
- R10: While busy is high, start is ignored. A pulse on start, with any other inputs, leaves the command and beat stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a transfer when idle |
| startCol | input | COL_W | Start column of the transfer |
| lenCode | input | 2 | Beat count: 0=1, 1=4, 2=8, 3=16 |
| sdrMode | input | 1 | 1 selects single-data-rate behaviour |
| busy | output | 1 | A transfer is in progress |
| cmdWrite | output | 1 | Issue a WRITE command this cycle |
| cmdStop | output | 1 | Issue a burst-stop command this cycle |
| cmdCol | output | COL_W | Column of the WRITE command |
| beatValid | output | 1 | A beat slot is driven this cycle |
| beatMask | output | 1 | Data mask for the beat slot, high = ignore |
| beatCol | output | COL_W | Column the beat slot lands on |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A corrupted remaining-beat count or segment column shows up first in cmdCol of the next WRITE, or in the mask boundary inside the current burst. Both are visible within at most eight cycles. A slot counter out of step moves the next WRITE or the done pulse by whole cycles, so a cycle-exact comparison of the full stream catches it at once. Sweeping every start offset across two groups, in both modes and with all four lengths, drives every split count and every mask boundary position.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int BURST = 8;
  localparam int OFF_W = $clog2(BURST);

  typedef struct packed {
    logic load;
    logic incSlot;
    logic advance;
  } ctrlStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_STOP,
    ST_FIN
  } ctrlStateT;

  function automatic logic [4:0] beatsOf(input logic [1:0] code);
    case (code)
      2'd0:    beatsOf = 5'd1;
      2'd1:    beatsOf = 5'd4;
      2'd2:    beatsOf = 5'd8;
      default: beatsOf = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/bws_datapath.sv
module bws_datapath
  import bws_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  output logic             lastSeg,
  output logic             slotLast,
  output logic [COL_W-1:0] cmdCol,
  output logic             beatMask,
  output logic [COL_W-1:0] beatCol
);
  localparam int SEG_W = OFF_W + 1;

  logic [COL_W-1:0] curCol;
  logic [CNT_W-1:0] remain;
  logic [OFF_W-1:0] slot;
  logic [SEG_W-1:0] avail;
  logic [SEG_W-1:0] segLen;
  logic [OFF_W-1:0] landOff;

  // room left in the current aligned group
  assign avail  = SEG_W'(BURST) - {1'b0, curCol[OFF_W-1:0]};
  assign segLen = (remain < CNT_W'(avail)) ? SEG_W'(remain) : avail;
  assign lastSeg  = (remain <= CNT_W'(avail));
  assign slotLast = (slot == OFF_W'(BURST - 1));

  assign cmdCol   = curCol;
  assign landOff  = curCol[OFF_W-1:0] + slot;
  assign beatCol  = {curCol[COL_W-1:OFF_W], landOff};
  assign beatMask = ({1'b0, slot} >= segLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCol <= '0;
      remain <= '0;
      slot   <= '0;
    end else if (strobe.load) begin
      curCol <= startCol;
      remain <= CNT_W'(beatsOf(lenCode));
      slot   <= '0;
    end else if (strobe.advance) begin
      curCol <= curCol + COL_W'(segLen);
      remain <= remain - CNT_W'(segLen);
      slot   <= '0;
    end else if (strobe.incSlot) begin
      slot   <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/bws_control.sv
module bws_control
  import bws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] lenCode,
  input  logic       sdrMode,
  input  logic       lastSeg,
  input  logic       slotLast,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       cmdWrite,
  output logic       cmdStop,
  output logic       beatValid,
  output logic       done
);
  ctrlStateT state, nextState;
  logic sdrQ, singleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sdrQ    <= 1'b0;
      singleQ <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.load) begin
        sdrQ    <= sdrMode;
        singleQ <= (lenCode == 2'd0);
      end
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    cmdWrite  = 1'b0;
    cmdStop   = 1'b0;
    beatValid = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_CMD;
        end
      end
      ST_CMD: begin
        cmdWrite = 1'b1;
        if (sdrQ) begin
          beatValid      = 1'b1;
          strobe.incSlot = 1'b1;
          nextState      = singleQ ? ST_STOP : ST_DATA;
        end else begin
          nextState = ST_DATA;
        end
      end
      ST_DATA: begin
        beatValid = 1'b1;
        if (slotLast) begin
          strobe.advance = 1'b1;
          nextState      = lastSeg ? ST_FIN : ST_CMD;
        end else begin
          strobe.incSlot = 1'b1;
        end
      end
      ST_STOP: begin
        cmdStop        = 1'b1;
        strobe.advance = 1'b1;
        nextState      = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/burst_wrap_splitter.sv
module burst_wrap_splitter
  import bws_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  input  logic             sdrMode,
  output logic             busy,
  output logic             cmdWrite,
  output logic             cmdStop,
  output logic [COL_W-1:0] cmdCol,
  output logic             beatValid,
  output logic             beatMask,
  output logic [COL_W-1:0] beatCol,
  output logic             done
);
  localparam int CNT_W = 5;

  ctrlStrobeT strobe;
  logic lastSeg, slotLast;

  bws_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenCode(lenCode),
    .sdrMode(sdrMode), .lastSeg(lastSeg), .slotLast(slotLast),
    .strobe(strobe), .busy(busy), .cmdWrite(cmdWrite), .cmdStop(cmdStop),
    .beatValid(beatValid), .done(done)
  );

  bws_datapath #(.COL_W(COL_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .lenCode(lenCode), .lastSeg(lastSeg), .slotLast(slotLast),
    .cmdCol(cmdCol), .beatMask(beatMask), .beatCol(beatCol)
  );
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             cmdWrite,
  input logic             cmdStop,
  input logic [COL_W-1:0] cmdCol,
  input logic             beatValid,
  input logic             done
);
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdWrite && cmdStop)); // R7
  AST_STOP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |-> $past(cmdWrite)); // R7
  AST_STOP_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |=> done); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R9
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(beatValid) || $past(cmdStop))); // R9
  AST_WRITE_FOLLOWED: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> (beatValid || cmdStop)); // R4
  AST_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite || beatValid) |-> busy); // R1
  AST_COL_STABLE_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !cmdWrite && $past(beatValid)) |-> $stable(cmdCol)); // R8
endmodule

bind burst_wrap_splitter bws_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cmdWrite(cmdWrite),
  .cmdStop(cmdStop), .cmdCol(cmdCol), .beatValid(beatValid), .done(done)
);

// File: tb/burst_wrap_splitter_tb.sv
module burst_wrap_splitter_tb;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [1:0] lenCode = '0;
  logic sdrMode = 1'b0;
  logic busy, cmdWrite, cmdStop, beatValid, beatMask, done;
  logic [COL_W-1:0] cmdCol, beatCol;

  int nRun = 0;
  int nFail = 0;
  int nWrites = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_wrap_splitter #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .lenCode(lenCode), .sdrMode(sdrMode), .busy(busy), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .cmdCol(cmdCol), .beatValid(beatValid),
    .beatMask(beatMask), .beatCol(beatCol), .done(done)
  );

  task automatic chk(input string req, input bit eW, input bit eS,
                     input int eC, input bit eV, input bit eM, input int eB,
                     input bit eD, input bit eBusy);
    bit bad;
    bad = (cmdWrite !== eW) || (cmdStop !== eS) || (beatValid !== eV) ||
          (done !== eD) || (busy !== eBusy);
    if (eW && (cmdCol !== COL_W'(eC))) bad = 1;
    if (eV && ((beatMask !== eM) || (beatCol !== COL_W'(eB)))) bad = 1;
    if (cmdWrite === 1'b1) nWrites++;
    nRun++;
    if (bad) begin
      nFail++;
      $display("FAIL %s: actual w=%0b s=%0b col=%0d v=%0b m=%0b bc=%0d d=%0b b=%0b expected w=%0b s=%0b col=%0d v=%0b m=%0b bc=%0d d=%0b b=%0b",
               req, cmdWrite, cmdStop, cmdCol, beatValid, beatMask, beatCol, done, busy,
               eW, eS, eC, eV, eM, eB, eD, eBusy);
    end
  endtask

  // inject: pulse start with other inputs during the transfer (R10)
  task automatic runXfer(input int col, input int code, input bit sdr, input bit inject);
    int beats, rem, c, o, seg, k, cyc, expW;
    string tag;
    beats = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
    expW = ((col % 8) + beats + 7) / 8;
    nWrites = 0;
    @(negedge clk);
    start = 1'b1; startCol = COL_W'(col); lenCode = 2'(code); sdrMode = sdr;
    rem = beats; c = col; cyc = 0;
    while (rem > 0) begin
      o = c % 8;
      seg = (rem < 8 - o) ? rem : 8 - o;
      @(negedge clk); cyc++;
      start = 1'b0;
      if (inject && cyc == 3) begin
        start = 1'b1; startCol = COL_W'(col + 5); lenCode = 2'(3 - code); sdrMode = !sdr;
      end
      tag = inject ? "R10" : (c == col ? "R2" : "R2 aligned");
      if (sdr) chk(inject ? "R10" : "R5", 1, 0, c, 1, 0, c, 0, 1);
      else     chk(tag, 1, 0, c, 0, 0, 0, 0, 1);
      if (sdr && code == 0) begin
        @(negedge clk); cyc++;
        chk(inject ? "R10" : "R7", 0, 1, 0, 0, 0, 0, 0, 1);
      end else begin
        for (int kk = (sdr ? 1 : 0); kk < 8; kk++) begin
          k = kk;
          @(negedge clk); cyc++;
          if (inject && cyc == 3) begin
            start = 1'b1; startCol = COL_W'(col + 5); lenCode = 2'(3 - code); sdrMode = !sdr;
          end else start = 1'b0;
          if (inject) tag = "R10";
          else if (code == 0) tag = "R6";
          else if (k == 0) tag = "R4";
          else tag = "R8";
          chk(tag, 0, 0, 0, 1, (k >= seg), (c - o) + ((o + k) % 8), 0, 1);
        end
      end
      c = c + seg;
      rem = rem - seg;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R9", 0, 0, 0, 0, 0, 0, 1, 1);
    @(negedge clk);
    chk("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    nRun++;
    if (nWrites != expW) begin
      nFail++;
      $display("FAIL R3: actual writes=%0d expected=%0d (col=%0d beats=%0d)",
               nWrites, expW, col, beats);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int sdr = 0; sdr < 2; sdr++)
      for (int code = 0; code < 4; code++)
        for (int col = 0; col < 18; col++)
          runXfer(col + 1000 * 0, code, sdr[0], 1'b0);
    // wrap of the column space at the top end
    runXfer(1020, 3, 1'b0, 1'b0);
    runXfer(1021, 3, 1'b1, 1'b0);
    // start pulses while busy
    runXfer(3, 3, 1'b0, 1'b1);
    runXfer(6, 1, 1'b1, 1'b1);
    runXfer(0, 0, 1'b0, 1'b1);
    runXfer(9, 0, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule